// File: doc/BRIEF.md
# Nibble ALU with Conditional Skip

This block is the execute stage of a 4-bit controller whose instructions are single 16-bit words. Each accepted instruction carries a 6-bit opcode in bits [15:10], a data-memory row in [9:8], a data-memory column in [7:4] and, in [3:0], either a register number or a 4-bit immediate. The surrounding pipeline reads the two operands and presents them together with the instruction. One operand is the general register r, which is the nibble at row 0, column Rn. The other is the memory nibble M at the addressed row and column.

Results appear one clock after the instruction is accepted. The outputs give a write enable, a 6-bit destination address (row and column) and the nibble to write. They also give the carry/borrow flag and a skip flag. While the skip flag is set, the block cancels the next valid instruction: that instruction writes nothing, leaves the flag alone and clears the skip. The block covers these operations:

- add and subtract, with or without the incoming carry or borrow, in register form (r with M into r) or immediate form (M with I into M);
- a sibling of each arithmetic opcode that also skips on carry-out or borrow;
- equality and greater-or-equal compares, which skip and never write;
- AND and OR with an immediate, and XOR;
- load, store and move-immediate.

Top module: `nibble_exec_unit`

## Requirements
- R1: While rst_n is low and after its release, wr_en_o, wr_addr_o, wr_data_o, carry_o and skip_o are all 0.
- R2: Outputs change only on the rising clock edge after a valid instruction is accepted. A register-form destination is address {2'b00, instr[3:0]}, and a memory destination is {instr[9:8], instr[7:4]}.
- R3: Opcodes 010000 (r←r+M), 010010 (r←r+M+C), 010100 (M←M+I) and 010110 (M←M+I+C) write the low 4 bits of the sum. They set carry_o to the carry out of bit 3.
- R4: Opcodes 011000 (r←r−M), 011010 (r←r−M−C), 011100 (M←M−I) and 011110 (M←M−I−C) write the 4-bit difference. They set carry_o to 1 on borrow and to 0 otherwise.
- R5: An arithmetic opcode with bit 10 set (opcode[0]=1) does the same operation as its even sibling and sets skip_o equal to the new carry_o. Even arithmetic opcodes clear skip_o.
- R6: 000001 skips if r==M, 000011 if r>=M, 001101 if M==I and 001111 if M>=I (unsigned). Compares write nothing and leave carry_o unchanged.
- R7: 001100 writes M AND I to M, 001110 writes M OR I to M, and 001000 writes r XOR M to r. Each leaves carry_o unchanged and clears skip_o.
- R8: 100000 writes M to r, 100001 writes r to M and 100101 writes I to M. Each leaves carry_o unchanged and clears skip_o.
- R9: A valid instruction accepted while skip_o is 1 writes nothing, leaves carry_o unchanged and clears skip_o.
- R10: In a cycle with valid_i low, the next outputs have wr_en_o at 0, and skip_o and carry_o are held.
- R11: Every other opcode writes nothing, leaves carry_o unchanged and clears skip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction and operands are present this cycle |
| instr_i | input | 16 | Instruction word |
| reg_val_i | input | 4 | Contents of general register r (row 0, column Rn) |
| mem_val_i | input | 4 | Contents of memory nibble M at row/column |
| wr_en_o | output | 1 | Write-back strobe |
| wr_addr_o | output | 6 | Write-back address {row, column} |
| wr_data_o | output | 4 | Write-back nibble |
| carry_o | output | 1 | Carry/borrow flag |
| skip_o | output | 1 | Cancel the next valid instruction |

## Verification
The bound checker watches the cycle-level rules on every clock. A cancelled instruction writes nothing and changes no flag. Idle cycles hold the skip and the carry. Compares and undefined opcodes never write. A skipping arithmetic sibling leaves skip equal to the new carry, and an even sibling clears it. The sums, differences, logic results, compare outcomes and exact write addresses can only be shown by the bench's scenarios. It sweeps every one of the 64 opcodes against every pair of operand values, with the incoming carry forced both ways.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int OPC_W = 6;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_CEQ, K_CGE,
        K_AND, K_OR, K_XOR, K_LOAD, K_STORE, K_MOVI
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  imm_form;   // operands are M and I instead of r and M
        logic  use_cin;    // fold stored carry/borrow into arithmetic
        logic  skip_flag;  // skip when the arithmetic flag is produced
        logic  to_reg;     // destination is the general register
    } dec_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output dec_t             dec
);
    always_comb begin
        dec = '{kind: K_NONE, imm_form: 1'b0, use_cin: 1'b0,
                skip_flag: 1'b0, to_reg: 1'b0};
        if (opc[5:4] == 2'b01) begin
            dec.kind      = opc[3] ? K_SUB : K_ADD;
            dec.imm_form  = opc[2];
            dec.use_cin   = opc[1];
            dec.skip_flag = opc[0];
            dec.to_reg    = ~opc[2];
        end else begin
            unique case (opc)
                6'b000001: dec.kind = K_CEQ;
                6'b000011: dec.kind = K_CGE;
                6'b001101: begin dec.kind = K_CEQ; dec.imm_form = 1'b1; end
                6'b001111: begin dec.kind = K_CGE; dec.imm_form = 1'b1; end
                6'b001100: dec.kind = K_AND;
                6'b001110: dec.kind = K_OR;
                6'b001000: begin dec.kind = K_XOR; dec.to_reg = 1'b1; end
                6'b100000: begin dec.kind = K_LOAD; dec.to_reg = 1'b1; end
                6'b100001: dec.kind = K_STORE;
                6'b100101: dec.kind = K_MOVI;
                default:   dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/nib_arith.sv
module nib_arith #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         flag
);
    logic [W:0] ext;

    always_comb begin
        if (sub)
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = ext[W-1:0];
        flag = ext[W];   // carry out for add, borrow for subtract
    end
endmodule

// File: rtl/nibble_exec_unit.sv
module nibble_exec_unit
    import nib_pkg::*;
#(
    parameter  int DATA_W  = 4,
    parameter  int ROW_W   = 2,
    parameter  int COL_W   = 4,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int INSTR_W = OPC_W + ROW_W + COL_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  reg_val_i,
    input  logic [DATA_W-1:0]  mem_val_i,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               carry_o,
    output logic               skip_o
);
    typedef struct packed {
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              carry;
        logic              skip;
    } st_t;

    st_t st_d, st_q;

    logic [OPC_W-1:0]  opc;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] low;
    logic [ADDR_W-1:0] mem_addr, reg_addr;
    logic [DATA_W-1:0] op_a, op_b, ar_res;
    logic              ar_flag, cin;
    dec_t              dec;

    assign opc      = instr_i[INSTR_W-1 -: OPC_W];
    assign row      = instr_i[DATA_W+COL_W +: ROW_W];
    assign col      = instr_i[DATA_W +: COL_W];
    assign low      = instr_i[DATA_W-1:0];
    assign mem_addr = {row, col};
    assign reg_addr = ADDR_W'(low);   // general register lives in row 0

    nib_decode u_dec (
        .opc (opc),
        .dec (dec)
    );

    assign op_a = dec.imm_form ? mem_val_i : reg_val_i;
    assign op_b = dec.imm_form ? low       : mem_val_i;
    assign cin  = dec.use_cin & st_q.carry;

    nib_arith #(.W(DATA_W)) u_arith (
        .a    (op_a),
        .b    (op_b),
        .cin  (cin),
        .sub  (dec.kind == K_SUB),
        .res  (ar_res),
        .flag (ar_flag)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (valid_i) begin
            st_d.skip = 1'b0;
            if (!st_q.skip) begin
                unique case (dec.kind)
                    K_ADD, K_SUB: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = dec.to_reg ? reg_addr : mem_addr;
                        st_d.data  = ar_res;
                        st_d.carry = ar_flag;
                        st_d.skip  = dec.skip_flag & ar_flag;
                    end
                    K_CEQ: st_d.skip = (op_a == op_b);
                    K_CGE: st_d.skip = (op_a >= op_b);
                    K_AND: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = mem_addr;
                        st_d.data  = mem_val_i & low;
                    end
                    K_OR: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = mem_addr;
                        st_d.data  = mem_val_i | low;
                    end
                    K_XOR: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = reg_addr;
                        st_d.data  = reg_val_i ^ mem_val_i;
                    end
                    K_LOAD: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = reg_addr;
                        st_d.data  = mem_val_i;
                    end
                    K_STORE: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = mem_addr;
                        st_d.data  = reg_val_i;
                    end
                    K_MOVI: begin
                        st_d.wr_en = 1'b1;
                        st_d.addr  = mem_addr;
                        st_d.data  = low;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.addr;
    assign wr_data_o = st_q.data;
    assign carry_o   = st_q.carry;
    assign skip_o    = st_q.skip;
endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk #(
    parameter int INSTR_W = 16,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic               wr_en_o,
    input logic [ADDR_W-1:0]  wr_addr_o,
    input logic [DATA_W-1:0]  wr_data_o,
    input logic               carry_o,
    input logic               skip_o
);
    logic [5:0] opc;
    logic       is_arith, is_cmp, is_move, is_logic, live;

    assign opc      = instr_i[INSTR_W-1 -: 6];
    assign is_arith = (opc[5:4] == 2'b01);
    assign is_cmp   = (opc == 6'b000001) || (opc == 6'b000011) ||
                      (opc == 6'b001101) || (opc == 6'b001111);
    assign is_logic = (opc == 6'b001100) || (opc == 6'b001110) || (opc == 6'b001000);
    assign is_move  = (opc == 6'b100000) || (opc == 6'b100001) || (opc == 6'b100101);
    assign live     = valid_i && !skip_o;

    // R9
    squash_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && skip_o |=> !wr_en_o && !skip_o && $stable(carry_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !wr_en_o && $stable(skip_o) && $stable(carry_o));

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && is_cmp |=> !wr_en_o && $stable(carry_o));

    // R5
    skip_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && is_arith && opc[0] |=> wr_en_o && (skip_o == carry_o));

    // R5
    plain_arith_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && is_arith && !opc[0] |=> wr_en_o && !skip_o);

    // R8
    move_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && is_move |=> wr_en_o && !skip_o && $stable(carry_o));

    // R7
    logic_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && is_logic |=> wr_en_o && !skip_o && $stable(carry_o));

    // R11
    undef_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && !is_arith && !is_cmp && !is_logic && !is_move
        |=> !wr_en_o && !skip_o && $stable(carry_o));
endmodule

bind nibble_exec_unit nib_exec_chk #(
    .INSTR_W (INSTR_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .carry_o   (carry_o),
    .skip_o    (skip_o)
);

// File: tb/sim_nibble_exec_unit.sv
module sim_nibble_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [3:0]  reg_val_i = '0;
    logic [3:0]  mem_val_i = '0;
    logic        wr_en_o, carry_o, skip_o;
    logic [5:0]  wr_addr_o;
    logic [3:0]  wr_data_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit mc = 1'b0, ms = 1'b0;   // model carry and skip

    always #10 clk = ~clk;   // 50 MHz

    nibble_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .reg_val_i(reg_val_i), .mem_val_i(mem_val_i), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .carry_o(carry_o),
        .skip_o(skip_o)
    );

    task automatic check_all(string tag, bit ew, logic [5:0] ea, logic [3:0] ed,
                             bit ec, bit es);
        bit bad;
        checks++;
        bad = (wr_en_o !== ew) || (carry_o !== ec) || (skip_o !== es) ||
              (ew && ((wr_addr_o !== ea) || (wr_data_o !== ed)));
        if (bad) begin
            errors++;
            $display("FAIL %s instr=%h: got w=%b a=%h d=%h c=%b s=%b exp w=%b a=%h d=%h c=%b s=%b",
                     tag, instr_i, wr_en_o, wr_addr_o, wr_data_o, carry_o, skip_o,
                     ew, ea, ed, ec, es);
        end
    endtask

    // Issue one instruction; operands r = x^6, M = y, low nibble = x.
    task automatic issue(logic [5:0] op, logic [3:0] x, logic [3:0] y);
        int r, m, i, a, b, s;
        bit ew, ec, es;
        logic [5:0] ea, ra, ma;
        logic [3:0] ed;
        string tag;
        logic [1:0] dh;
        logic [3:0] dl;
        r = int'(x ^ 4'd6); m = int'(y); i = int'(x);
        dh = y[1:0] ^ x[3:2]; dl = ~y;
        ma = {dh, dl}; ra = {2'b00, x};
        instr_i = {op, dh, dl, x}; reg_val_i = x ^ 4'd6; mem_val_i = y;
        valid_i = 1'b1;
        ew = 0; ea = '0; ed = '0; ec = mc; es = 0; tag = "R11";
        if (ms) tag = "R9";
        else casez (op)
            6'b010???: begin
                a = op[2] ? m : r; b = op[2] ? i : m;
                s = a + b + (op[1] ? int'(mc) : 0);
                ew = 1; ea = op[2] ? ma : ra; ed = 4'(s % 16); ec = (s > 15);
                es = op[0] && ec; tag = op[0] ? "R5" : (op[2] ? "R3" : "R2 R3");
            end
            6'b011???: begin
                a = op[2] ? m : r; b = op[2] ? i : m;
                s = a - b - (op[1] ? int'(mc) : 0);
                ew = 1; ea = op[2] ? ma : ra; ed = 4'((s + 32) % 16); ec = (s < 0);
                es = op[0] && ec; tag = op[0] ? "R5" : "R4";
            end
            6'b000001: begin es = (r == m); tag = "R6"; end
            6'b000011: begin es = (r >= m); tag = "R6"; end
            6'b001101: begin es = (m == i); tag = "R6"; end
            6'b001111: begin es = (m >= i); tag = "R6"; end
            6'b001100: begin ew = 1; ea = ma; ed = 4'(m & i); tag = "R7"; end
            6'b001110: begin ew = 1; ea = ma; ed = 4'(m | i); tag = "R7"; end
            6'b001000: begin ew = 1; ea = ra; ed = 4'(r ^ m); tag = "R7"; end
            6'b100000: begin ew = 1; ea = ra; ed = 4'(m); tag = "R8"; end
            6'b100001: begin ew = 1; ea = ma; ed = 4'(r); tag = "R2 R8"; end
            6'b100101: begin ew = 1; ea = ma; ed = 4'(i); tag = "R8"; end
            default: ;
        endcase
        @(negedge clk);
        check_all(tag, ew, ea, ed, ec, es);
        mc = ec; ms = es;
    endtask

    task automatic idle(int n);
        valid_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_all("R10", 1'b0, '0, '0, mc, ms);
        end
    endtask

    task automatic set_carry(bit c);
        if (ms) issue(6'b111111, 4'd0, 4'd0);   // absorbed by the pending skip
        issue(6'b010100, {3'b000, c}, 4'hF);    // 15 + c
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, '0, '0, 1'b0, 1'b0);
        checks++;
        if (wr_addr_o !== '0 || wr_data_o !== '0) begin
            errors++;
            $display("FAIL R1 addr=%h data=%h exp 0 0", wr_addr_o, wr_data_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0, '0, '0, 1'b0, 1'b0);

        // R10 and R9: skip pending across idle cycles, then cancels an add
        issue(6'b000001, 4'd0, 4'd6);   // r = 6, M = 6: equal, skips
        idle(3);
        issue(6'b010000, 4'd3, 4'd4);   // cancelled
        idle(1);

        // Exhaustive opcode x operand sweep, both incoming carry values
        for (int op = 0; op < 64; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int x = 0; x < 16; x++) begin
                    for (int y = 0; y < 16; y++) begin
                        set_carry(c[0]);
                        issue(6'(op), 4'(x), 4'(y));
                    end
                end
            end
        end
        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule